// File: doc/BRIEF.md
# Chunked Context Swap Controller

This controller sits between a preemptible hardware core and a processor. It moves the core's execution context out through a small buffer, and later moves it back in. A swap-out command raises the core's swap line. The core keeps running until it reaches a state it can resume from. There it presents its context words, including its state encoding, and raises an acknowledge. The controller then copies the context into its buffer one chunk at a time. For each chunk it raises an interrupt, and software empties the chunk through a register port before the controller refills the buffer from the next part of the context. When every chunk has been taken, a swap-finished line tells software that the core's logic may be released.

For a swap-in, software issues a command and then writes the saved context back, one chunk per interrupt. After each chunk is complete, the controller copies the buffered words into the core's registers, one indexed write per cycle. When the last chunk has been loaded, it drops the swap line and the core resumes from the restored state.

The context holds `CTX_WORDS` words and the buffer holds `BUF_WORDS` words. The context may be larger than the buffer, in which case the transfer takes several rounds.

Top module: `ctx_swap_ctrl`

## Requirements
- R1: A register write to address 0 with bit 0 set is a swap-out command. When the block is idle, this command drives `core_swap_o` high from the next cycle. The line then stays high until the last swap-in word has been loaded into the core.
- R2: No chunk fill and no interrupt happen before `core_ack_i` is seen. The first interrupt rises exactly `BUF_WORDS`+1 cycles after the cycle in which the acknowledge is sampled.
- R3: While an outgoing chunk is pending, each read of address 1 returns the next context word. Context word i is `core_ctx_i[i*DATA_W +: DATA_W]`, and chunk c, position k carries word c*`BUF_WORDS`+k.
- R4: A swap-out raises ceil(`CTX_WORDS`/`BUF_WORDS`) interrupts. Every chunk holds `BUF_WORDS` words except the last, which holds the remainder.
- R5: `swap_fin_o` rises once the last chunk has been acknowledged. While it is high, `core_swap_o` stays high and `irq_o` stays low. It holds until a swap-in command is accepted.
- R6: A register write to address 0 with bit 1 set is a swap-in command. After it, each chunk written to address 1 is loaded into the core through `core_wr_o`/`core_widx_o`/`core_wdata_o`. Exactly `CTX_WORDS` writes are made, and the core registers end up equal to the saved context bit for bit.
- R7: A swap-in command issued during a swap-out, before `swap_fin_o` rises, has no effect on the transfer.
- R8: `irq_o` stays high until software acknowledges the chunk. A read of the chunk's final word acknowledges it, and so does any write to address 2.
- R9: A write to address 2 ends the current chunk early. The unread words of that chunk are skipped, and the next chunk starts at its first word.
- R10: During reset, `core_swap_o`, `irq_o`, `swap_fin_o` and `core_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write (1) or read (0) |
| reg_addr_i | input | 2 | Register address: 0 command, 1 data, 2 chunk clear |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, valid in the strobe cycle |
| irq_o | output | 1 | Chunk ready or chunk wanted |
| swap_fin_o | output | 1 | Context fully saved; the core may be released |
| core_swap_o | output | 1 | Swap request to the core |
| core_ack_i | input | 1 | Core is at an interruptible state with its context presented |
| core_ctx_i | input | CTX_WORDS*DATA_W | Context words presented by the core |
| core_wr_o | output | 1 | Restore write strobe |
| core_widx_o | output | IDX_W | Restore word index |
| core_wdata_o | output | DATA_W | Restore word data |

## Verification
The bench builds the block with a ten-word context and a four-word buffer. This gives three chunks, and the last one holds only two words, so the rounded-up chunk count and the short final chunk are both exercised. Four swap-out/swap-in rounds follow, each with a different context pattern and a different acknowledge delay. These rounds also cover a swap-in command sent in the middle of a swap-out and a chunk ended early through the clear register. Every round compares the reloaded core registers against the context the core presented.

// File: rtl/ctx_swap_pkg.sv
package ctx_swap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ACK,
    ST_FILL,
    ST_OUT_IRQ,
    ST_PARKED,
    ST_IN_IRQ,
    ST_DRAIN
  } swap_st_e;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;

  localparam int CMD_OUT_BIT = 0;
  localparam int CMD_IN_BIT  = 1;

endpackage

// File: rtl/ctx_chunk_seq.sv
module ctx_chunk_seq #(
  parameter int CTX_WORDS = 10,
  parameter int BUF_WORDS = 4,
  localparam int NCH      = (CTX_WORDS + BUF_WORDS - 1) / BUF_WORDS,
  localparam int LAST_LEN = CTX_WORDS - (NCH - 1) * BUF_WORDS,
  localparam int CW       = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WW       = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
  localparam int GW       = $clog2(NCH * BUF_WORDS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          all_clr_i,
  input  logic          word_inc_i,
  input  logic          word_clr_i,
  input  logic          chunk_inc_i,
  output logic [WW-1:0] word_o,
  output logic [GW-1:0] gidx_o,
  output logic          last_word_o,
  output logic          last_chunk_o
);

  logic [CW-1:0] chunk_q;
  logic [WW-1:0] word_q;
  int            cur_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chunk_q <= '0;
      word_q  <= '0;
    end else if (all_clr_i) begin
      chunk_q <= '0;
      word_q  <= '0;
    end else begin
      if (word_clr_i)      word_q <= '0;
      else if (word_inc_i) word_q <= word_q + 1'b1;
      if (chunk_inc_i)     chunk_q <= chunk_q + 1'b1;
    end
  end

  assign last_chunk_o = (chunk_q == CW'(NCH - 1));
  assign cur_len      = last_chunk_o ? LAST_LEN : BUF_WORDS;
  assign last_word_o  = (word_q == WW'(cur_len - 1));
  assign word_o       = word_q;
  assign gidx_o       = GW'(chunk_q) * GW'(BUF_WORDS) + GW'(word_q);

endmodule

// File: rtl/ctx_chunk_buf.sv
module ctx_chunk_buf #(
  parameter int BUF_WORDS = 4,
  parameter int DATA_W    = 16,
  localparam int WW       = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WW-1:0]     idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [BUF_WORDS];

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[g] <= '0;
      else if (we_i && (idx_i == WW'(g)))    mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < BUF_WORDS; i++)
      if (idx_i == WW'(i)) rdata_o = mem_q[i];
  end

endmodule

// File: rtl/ctx_swap_ctrl.sv
module ctx_swap_ctrl
  import ctx_swap_pkg::*;
#(
  parameter int CTX_WORDS = 10,
  parameter int BUF_WORDS = 4,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        reg_req_i,
  input  logic                        reg_we_i,
  input  logic [1:0]                  reg_addr_i,
  input  logic [DATA_W-1:0]           reg_wdata_i,
  output logic [DATA_W-1:0]           reg_rdata_o,
  output logic                        irq_o,
  output logic                        swap_fin_o,
  output logic                        core_swap_o,
  input  logic                        core_ack_i,
  input  logic [CTX_WORDS*DATA_W-1:0] core_ctx_i,
  output logic                        core_wr_o,
  output logic [IDX_W-1:0]            core_widx_o,
  output logic [DATA_W-1:0]           core_wdata_o
);

  localparam int NCH = (CTX_WORDS + BUF_WORDS - 1) / BUF_WORDS;
  localparam int WW  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
  localparam int GW  = $clog2(NCH * BUF_WORDS + 1);

  swap_st_e st_q, st_d;

  logic          all_clr, word_inc, word_clr, chunk_inc;
  logic [WW-1:0] word;
  logic [GW-1:0] gidx;
  logic          last_word, last_chunk;

  logic              buf_we;
  logic [DATA_W-1:0] buf_wdata, buf_rdata, ctx_sel;
  logic [DATA_W-1:0] ctx_words [CTX_WORDS];

  logic cmd_wr, out_cmd, in_cmd, data_rd, data_wr, clr_wr;

  assign cmd_wr  = reg_req_i && reg_we_i && (reg_addr_i == ADDR_CMD);
  assign out_cmd = cmd_wr && reg_wdata_i[CMD_OUT_BIT];
  assign in_cmd  = cmd_wr && reg_wdata_i[CMD_IN_BIT];
  assign data_rd = reg_req_i && !reg_we_i && (reg_addr_i == ADDR_DATA);
  assign data_wr = reg_req_i && reg_we_i && (reg_addr_i == ADDR_DATA);
  assign clr_wr  = reg_req_i && reg_we_i && (reg_addr_i == ADDR_CLR);

  for (genvar g = 0; g < CTX_WORDS; g++) begin : g_ctx
    assign ctx_words[g] = core_ctx_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    ctx_sel = '0;
    for (int i = 0; i < CTX_WORDS; i++)
      if (gidx == GW'(i)) ctx_sel = ctx_words[i];
  end

  ctx_chunk_seq #(
    .CTX_WORDS(CTX_WORDS),
    .BUF_WORDS(BUF_WORDS)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .all_clr_i    (all_clr),
    .word_inc_i   (word_inc),
    .word_clr_i   (word_clr),
    .chunk_inc_i  (chunk_inc),
    .word_o       (word),
    .gidx_o       (gidx),
    .last_word_o  (last_word),
    .last_chunk_o (last_chunk)
  );

  ctx_chunk_buf #(
    .BUF_WORDS(BUF_WORDS),
    .DATA_W   (DATA_W)
  ) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (buf_we),
    .idx_i   (word),
    .wdata_i (buf_wdata),
    .rdata_o (buf_rdata)
  );

  always_comb begin
    st_d      = st_q;
    all_clr   = 1'b0;
    word_inc  = 1'b0;
    word_clr  = 1'b0;
    chunk_inc = 1'b0;
    buf_we    = 1'b0;
    buf_wdata = reg_wdata_i;
    core_wr_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (out_cmd) begin
          all_clr = 1'b1;
          st_d    = ST_WAIT_ACK;
        end else if (in_cmd) begin
          all_clr = 1'b1;
          st_d    = ST_IN_IRQ;
        end
      end
      ST_WAIT_ACK: begin
        if (core_ack_i) st_d = ST_FILL;
      end
      ST_FILL: begin
        buf_we    = 1'b1;
        buf_wdata = ctx_sel;
        word_inc  = 1'b1;
        if (last_word) begin
          word_clr = 1'b1;
          st_d     = ST_OUT_IRQ;
        end
      end
      ST_OUT_IRQ: begin
        word_inc = data_rd;
        if (clr_wr || (data_rd && last_word)) begin
          word_clr = 1'b1;
          if (last_chunk) begin
            st_d = ST_PARKED;
          end else begin
            chunk_inc = 1'b1;
            st_d      = ST_FILL;
          end
        end
      end
      ST_PARKED: begin
        if (in_cmd) begin
          all_clr = 1'b1;
          st_d    = ST_IN_IRQ;
        end
      end
      ST_IN_IRQ: begin
        buf_we   = data_wr;
        word_inc = data_wr;
        if (clr_wr || (data_wr && last_word)) begin
          word_clr = 1'b1;
          st_d     = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        core_wr_o = 1'b1;
        word_inc  = 1'b1;
        if (last_word) begin
          word_clr = 1'b1;
          if (last_chunk) begin
            st_d = ST_IDLE;
          end else begin
            chunk_inc = 1'b1;
            st_d      = ST_IN_IRQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign core_swap_o  = (st_q != ST_IDLE);
  assign irq_o        = (st_q == ST_OUT_IRQ) || (st_q == ST_IN_IRQ);
  assign swap_fin_o   = (st_q == ST_PARKED);
  assign core_widx_o  = IDX_W'(gidx);
  assign core_wdata_o = buf_rdata;
  assign reg_rdata_o  = ((st_q == ST_OUT_IRQ) && (reg_addr_i == ADDR_DATA)) ? buf_rdata : '0;

endmodule

// File: rtl/ctx_swap_ctrl_chk.sv
module ctx_swap_ctrl_chk #(
  parameter int CTX_WORDS = 10,
  parameter int BUF_WORDS = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_req_i,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i,
  input logic [1:0] cmd_bits_i,
  input logic       irq_o,
  input logic       swap_fin_o,
  input logic       core_swap_o,
  input logic       core_ack_i,
  input logic       core_wr_o
);

  localparam int NCH = (CTX_WORDS + BUF_WORDS - 1) / BUF_WORDS;

  logic       out_wr, in_wr, in_acc;
  logic       in_mode_q, acked_q, irq_q;
  logic [7:0] rise_cnt_q;

  assign out_wr = reg_req_i && reg_we_i && (reg_addr_i == 2'd0) && cmd_bits_i[0];
  assign in_wr  = reg_req_i && reg_we_i && (reg_addr_i == 2'd0) && cmd_bits_i[1];
  assign in_acc = in_wr && ((!core_swap_o && !out_wr) || swap_fin_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_mode_q  <= 1'b0;
      acked_q    <= 1'b0;
      irq_q      <= 1'b0;
      rise_cnt_q <= '0;
    end else begin
      irq_q <= irq_o;
      if (in_acc)            in_mode_q <= 1'b1;
      else if (!core_swap_o) in_mode_q <= 1'b0;
      if (!core_swap_o)      acked_q <= 1'b0;
      else if (core_ack_i)   acked_q <= 1'b1;
      if (!core_swap_o || swap_fin_o) rise_cnt_q <= '0;
      else if (irq_o && !irq_q)       rise_cnt_q <= rise_cnt_q + 1'b1;
    end
  end

  p_cmd_raises_swap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_swap_o && out_wr) |=> core_swap_o);

  p_irq_after_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && !in_mode_q) |-> acked_q);

  p_chunks_rounded_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swap_fin_o) |-> (rise_cnt_q == 8'(NCH)));

  p_fin_parked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_fin_o |-> (core_swap_o && !irq_o));

  p_fin_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_fin_o && !in_wr) |=> swap_fin_o);

  p_load_only_swapped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_o |-> (core_swap_o && !irq_o && !swap_fin_o));

  p_no_load_in_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_swap_o && !swap_fin_o && !in_mode_q) |=> !core_wr_o);

  p_irq_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_req_i) |=> irq_o);

endmodule

bind ctx_swap_ctrl ctx_swap_ctrl_chk #(
  .CTX_WORDS(CTX_WORDS),
  .BUF_WORDS(BUF_WORDS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .cmd_bits_i  (reg_wdata_i[1:0]),
  .irq_o       (irq_o),
  .swap_fin_o  (swap_fin_o),
  .core_swap_o (core_swap_o),
  .core_ack_i  (core_ack_i),
  .core_wr_o   (core_wr_o)
);

// File: tb/ctx_swap_ctrl_bench.sv
module ctx_swap_ctrl_bench;

  localparam int CTX = 10;
  localparam int BUF = 4;
  localparam int DW  = 16;
  localparam int NCH = (CTX + BUF - 1) / BUF;
  localparam int IW  = $clog2(CTX);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req, we;
  logic [1:0]        addr;
  logic [DW-1:0]     wdata, rdata;
  logic              irq, fin, swap, ack, core_wr;
  logic [CTX*DW-1:0] core_ctx;
  logic [IW-1:0]     core_widx;
  logic [DW-1:0]     core_wdata;

  logic [DW-1:0] pat      [CTX];
  logic [DW-1:0] saved    [CTX];
  logic [DW-1:0] core_mem [CTX];
  int            n_wr;
  logic          wr_cnt_clr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ctx_swap_ctrl #(.CTX_WORDS(CTX), .BUF_WORDS(BUF), .DATA_W(DW)) u_ctx_swap_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .swap_fin_o(fin),
    .core_swap_o(swap), .core_ack_i(ack), .core_ctx_i(core_ctx),
    .core_wr_o(core_wr), .core_widx_o(core_widx), .core_wdata_o(core_wdata)
  );

  always_comb
    for (int i = 0; i < CTX; i++) core_ctx[i*DW +: DW] = pat[i];

  always @(posedge clk) begin
    if (wr_cnt_clr) n_wr <= 0;
    else if (core_wr) begin
      core_mem[core_widx] <= core_wdata;
      n_wr <= n_wr + 1;
    end
  end

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 50) begin
      @(posedge clk); #1;
      cyc++;
    end
  endtask

  task automatic run_round(input int r);
    int cyc, len, base;
    logic [DW-1:0] v;
    for (int i = 0; i < CTX; i++) pat[i] = DW'(r * 4099 + i * 257 + 16'h00A5);

    reg_wr(2'd0, 16'h0001);
    chk(swap == 1'b1, "R1 swap high after command", int'(swap), 1);
    if (r == 1) begin
      reg_wr(2'd0, 16'h0002);
      chk(irq == 1'b0 && fin == 1'b0, "R7 swap-in ignored during swap-out", int'(irq), 0);
    end
    for (int d = 0; d <= r; d++) begin
      @(posedge clk); #1;
      chk(irq == 1'b0, "R2 no interrupt before ack", int'(irq), 0);
    end
    @(negedge clk);
    ack = 1'b1;

    for (int c = 0; c < NCH; c++) begin
      wait_irq(cyc);
      chk(irq == 1'b1, "R4 chunk interrupt raised", int'(irq), 1);
      if (c == 0) chk(cyc == BUF + 1, "R2 fill latency after ack", cyc, BUF + 1);
      base = c * BUF;
      len  = (CTX - base < BUF) ? CTX - base : BUF;
      if (r == 3 && c == 0) begin
        reg_rd(2'd1, v);
        chk(v == pat[base], "R3 first word before clear", int'(v), int'(pat[base]));
        saved[base] = v;
        chk(irq == 1'b1, "R8 interrupt held mid-chunk", int'(irq), 1);
        reg_wr(2'd2, 16'h0000);
        chk(irq == 1'b0, "R9 clear ends chunk", int'(irq), 0);
        for (int k = 1; k < len; k++) saved[base + k] = pat[base + k];
      end else begin
        for (int k = 0; k < len; k++) begin
          if (k == len - 1) chk(irq == 1'b1, "R8 interrupt held until last read", int'(irq), 1);
          reg_rd(2'd1, v);
          chk(v == pat[base + k], "R3 context word order", int'(v), int'(pat[base + k]));
          saved[base + k] = v;
        end
        chk(irq == 1'b0, "R8 last read acknowledges chunk", int'(irq), 0);
      end
    end

    chk(fin == 1'b1 && swap == 1'b1 && irq == 1'b0, "R5 finished after last chunk", int'(fin), 1);
    repeat (5) @(posedge clk);
    #1;
    chk(fin == 1'b1 && irq == 1'b0, "R4 no extra chunk, R5 fin held", int'(irq), 0);
    @(negedge clk);
    ack = 1'b0;

    @(negedge clk);
    wr_cnt_clr = 1'b1;
    @(negedge clk);
    wr_cnt_clr = 1'b0;
    reg_wr(2'd0, 16'h0002);
    chk(fin == 1'b0 && swap == 1'b1, "R5 fin drops on swap-in", int'(fin), 0);
    for (int c = 0; c < NCH; c++) begin
      wait_irq(cyc);
      chk(irq == 1'b1, "R6 swap-in chunk request", int'(irq), 1);
      base = c * BUF;
      len  = (CTX - base < BUF) ? CTX - base : BUF;
      for (int k = 0; k < len; k++) reg_wr(2'd1, saved[base + k]);
    end
    cyc = 0;
    while (swap && cyc < 50) begin
      @(posedge clk); #1;
      cyc++;
    end
    chk(swap == 1'b0, "R1 swap low after restore", int'(swap), 0);
    chk(n_wr == CTX, "R6 restore write count", n_wr, CTX);
    for (int i = 0; i < CTX; i++)
      chk(core_mem[i] == pat[i], "R6 restored word matches", int'(core_mem[i]), int'(pat[i]));
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; ack = 1'b0;
    wr_cnt_clr = 1'b1;
    for (int i = 0; i < CTX; i++) pat[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(swap == 1'b0 && irq == 1'b0 && fin == 1'b0 && core_wr == 1'b0,
        "R10 reset outputs", int'({swap, irq, fin, core_wr}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wr_cnt_clr = 1'b0;
    for (int r = 0; r < 4; r++) run_round(r);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule